// File: doc/BRIEF.md
# Predicated Four-Lane Vector Execution Unit

This block holds eight 128-bit vector registers, each split into four 32-bit lanes, and executes vector instructions on them. Arithmetic instructions add or multiply lane by lane, taking the second operand either from a vector register or from a scalar that is copied into every lane. A compare instruction records a signed less/equal/greater result per lane in a flags register. Predicated add and multiply then update only the lanes whose chosen flag bit is set and leave every other lane of the destination as it was.

Memory instructions do not touch memory themselves. An address generator works out one address per lane, and the unit issues one lane request per cycle over four cycles. Addresses are either contiguous (a base plus a signed offset plus four bytes per lane) or taken from the lanes of an index register. Load data arrives on `mem_rdata` in the same cycle as its request. While a memory instruction is in progress the unit reports `busy` and drops any instruction that is offered.

Top module: `vpu_lane_exec`

## Requirements
- R1: After reset every vector register reads zero, `flags` is zero, and `res_valid`, `busy` and `mem_req_valid` are low.
- R2: Opcode 0 (add) writes `a[i] + b[i]` modulo 2^32 into every lane of `op_dst`. b is lane i of `op_srcb`, or `op_scalar` in every lane when `op_bscalar` is 1. One cycle after acceptance `res_valid` pulses, with `res_dst` set to the destination and `res_data` set to the register's new value.
- R3: Opcode 1 (multiply) writes the low 32 bits of `a[i] * b[i]` into every lane, and reports the result in the same way as R2.
- R4: Opcode 2 (compare) performs a signed compare of each lane of a against b and stores it in `flags[3*i+2:3*i]`, with bit 0 = less, bit 1 = equal and bit 2 = greater. It writes no register and gives no `res_valid`.
- R5: Opcodes 3 (predicated add) and 4 (predicated multiply) update lane i only when `flags[3*i+p]` is 1, where `op_pred` p is 0 = less, 1 = equal, 2 = greater. p = 3 enables no lane. Disabled lanes keep their old value, and `res_valid` still pulses with the whole register.
- R6: Opcodes 5 (contiguous load) and 6 (contiguous store) issue lanes 0..3 in consecutive cycles, starting in the cycle after acceptance. Lane i has address `op_scalar + sign_extend(op_offset) + 4*i`.
- R7: Opcodes 7 (gather load) and 8 (scatter store) take lane i's address from lane i of `op_srcb`, captured at acceptance. A gather whose destination is also its index register still uses the original addresses.
- R8: A store request has `mem_req_write` = 1 and carries lane i of `op_srca` as it stood at acceptance.
- R9: A load writes `mem_rdata`, as seen during lane i's request, into lane i of `op_dst`. `res_valid` pulses with the full new register one cycle after the lane 3 request.
- R10: While `busy` is high, an offered instruction is ignored: no register or flag changes and no `res_valid` for it.
- R11: Opcodes 9 to 15 are ignored: no register, flag or memory change and no `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Instruction offered this cycle |
| op_code | input | 4 | Opcode (see requirements) |
| op_dst | input | 3 | Destination register |
| op_srca | input | 3 | First source register / store data register |
| op_srcb | input | 3 | Second source register / index register |
| op_bscalar | input | 1 | Use `op_scalar` in place of `op_srcb` |
| op_scalar | input | 32 | Broadcast operand or contiguous base address |
| op_pred | input | 2 | Predicate selector |
| op_offset | input | 12 | Signed offset for contiguous access |
| busy | output | 1 | Memory instruction in progress |
| res_valid | output | 1 | Register write result valid |
| res_dst | output | 3 | Register written |
| res_data | output | 128 | New register contents |
| flags | output | 12 | Per-lane compare flags |
| mem_req_valid | output | 1 | Lane memory request |
| mem_req_write | output | 1 | Request is a store |
| mem_req_lane | output | 2 | Lane of the request |
| mem_req_addr | output | 32 | Lane byte address |
| mem_req_wdata | output | 32 | Store data for the lane |
| mem_rdata | input | 32 | Load data for the current request |

## Verification
The hardest case to reach from the ports is a gather load that overwrites its own index register. Each lane write changes the register the later lanes would read their addresses from, so a design that reads addresses lane by lane goes wrong only in this case. The bench first fills an index register through a contiguous load. It then scatters known data to those addresses and gathers them back into the index register itself, checking each lane's address against the snapshot taken before the instruction. A second hard case is an instruction offered in the middle of a load. The bench issues it on the cycle right after acceptance and then reads that register back.

// File: rtl/vx_pkg.sv
package vx_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_MUL  = 4'd1,
    OP_CMP  = 4'd2,
    OP_PADD = 4'd3,
    OP_PMUL = 4'd4,
    OP_LDC  = 4'd5,
    OP_STC  = 4'd6,
    OP_LDG  = 4'd7,
    OP_STG  = 4'd8
  } vop_e;

  localparam logic [1:0] PRED_NONE = 2'd3;
  localparam int FLAG_BITS = 3;  // {gt, eq, lt}
endpackage

// File: rtl/vx_regfile.sv
module vx_regfile #(
  parameter int NREG  = 8,
  parameter int LANES = 4,
  parameter int EW    = 32,
  parameter int NRD   = 3,
  localparam int AW   = $clog2(NREG),
  localparam int VW   = LANES * EW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LANES-1:0]     we_mask,
  input  logic [AW-1:0]        waddr,
  input  logic [VW-1:0]        wdata,
  input  logic [NRD*AW-1:0]    raddr,
  output logic [NRD*VW-1:0]    rdata
);
  logic [VW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) regs[r] <= '0;
    end else begin
      for (int l = 0; l < LANES; l++)
        if (we_mask[l]) regs[waddr][l*EW +: EW] <= wdata[l*EW +: EW];
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p*VW +: VW] = regs[raddr[p*AW +: AW]];
  end
endmodule

// File: rtl/vx_alu.sv
module vx_alu
  import vx_pkg::*;
#(
  parameter int LANES = 4,
  parameter int EW    = 32,
  localparam int VW   = LANES * EW
) (
  input  logic [3:0]             code,
  input  logic [1:0]             pred,
  input  logic [VW-1:0]          a_vec,
  input  logic [VW-1:0]          b_vec,
  input  logic [3*LANES-1:0]     flags_in,
  output logic [VW-1:0]          res_vec,
  output logic [LANES-1:0]       lane_en,
  output logic [3*LANES-1:0]     flags_out
);
  function automatic logic [EW-1:0] lane_sum(input logic [EW-1:0] x, input logic [EW-1:0] y);
    return x + y;
  endfunction

  function automatic logic [EW-1:0] lane_prod(input logic [EW-1:0] x, input logic [EW-1:0] y);
    logic [2*EW-1:0] full;
    full = {{EW{1'b0}}, x} * {{EW{1'b0}}, y};
    return full[EW-1:0];
  endfunction

  function automatic logic [2:0] lane_cmp(input logic [EW-1:0] x, input logic [EW-1:0] y);
    return {$signed(x) > $signed(y), x == y, $signed(x) < $signed(y)};
  endfunction

  logic is_mul, is_pred;
  assign is_mul  = (code == OP_MUL)  || (code == OP_PMUL);
  assign is_pred = (code == OP_PADD) || (code == OP_PMUL);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [EW-1:0] a, b;
    logic [2:0]    fl;
    assign a  = a_vec[l*EW +: EW];
    assign b  = b_vec[l*EW +: EW];
    assign fl = flags_in[l*3 +: 3];
    assign res_vec[l*EW +: EW] = is_mul ? lane_prod(a, b) : lane_sum(a, b);
    assign flags_out[l*3 +: 3] = lane_cmp(a, b);
    assign lane_en[l] = !is_pred ? 1'b1 : (pred == PRED_NONE) ? 1'b0 : fl[pred];
  end
endmodule

// File: rtl/vx_agu.sv
module vx_agu #(
  parameter int LANES = 4,
  parameter int EW    = 32,
  parameter int OFFW  = 12,
  localparam int VW   = LANES * EW
) (
  input  logic [EW-1:0]   base,
  input  logic [OFFW-1:0] offset,
  input  logic [VW-1:0]   idx_vec,
  input  logic            gather,
  output logic [VW-1:0]   addr_vec
);
  logic [EW-1:0] start;
  assign start = base + {{(EW-OFFW){offset[OFFW-1]}}, offset};

  for (genvar l = 0; l < LANES; l++) begin : g_addr
    assign addr_vec[l*EW +: EW] = gather ? idx_vec[l*EW +: EW] : start + EW'(4 * l);
  end
endmodule

// File: rtl/vpu_lane_exec.sv
module vpu_lane_exec
  import vx_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int LANES = 4,
  parameter int EW    = 32,
  parameter int OFFW  = 12,
  localparam int AW   = $clog2(NREG),
  localparam int LW   = $clog2(LANES),
  localparam int VW   = LANES * EW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_valid,
  input  logic [3:0]           op_code,
  input  logic [AW-1:0]        op_dst,
  input  logic [AW-1:0]        op_srca,
  input  logic [AW-1:0]        op_srcb,
  input  logic                 op_bscalar,
  input  logic [EW-1:0]        op_scalar,
  input  logic [1:0]           op_pred,
  input  logic [OFFW-1:0]      op_offset,
  output logic                 busy,
  output logic                 res_valid,
  output logic [AW-1:0]        res_dst,
  output logic [VW-1:0]        res_data,
  output logic [3*LANES-1:0]   flags,
  output logic                 mem_req_valid,
  output logic                 mem_req_write,
  output logic [LW-1:0]        mem_req_lane,
  output logic [EW-1:0]        mem_req_addr,
  output logic [EW-1:0]        mem_req_wdata,
  input  logic [EW-1:0]        mem_rdata
);
  // state
  logic                 busy_q, m_write, m_gather;
  logic [LW-1:0]        m_lane;
  logic [AW-1:0]        m_dst;
  logic [VW-1:0]        m_addr, m_wdata;
  logic [3*LANES-1:0]   flags_q;
  logic                 res_valid_q;
  logic [AW-1:0]        res_dst_q;
  logic [VW-1:0]        res_data_q;

  // named events
  logic op_accept, arith_fire, cmp_fire, mem_fire, load_last;
  logic is_arith, is_mem, is_gather, is_store;

  assign is_arith  = (op_code == OP_ADD) || (op_code == OP_MUL) ||
                     (op_code == OP_PADD) || (op_code == OP_PMUL);
  assign is_mem    = (op_code >= OP_LDC) && (op_code <= OP_STG);
  assign is_gather = (op_code == OP_LDG) || (op_code == OP_STG);
  assign is_store  = (op_code == OP_STC) || (op_code == OP_STG);

  assign op_accept  = op_valid && !busy_q;
  assign arith_fire = op_accept && is_arith;
  assign cmp_fire   = op_accept && (op_code == OP_CMP);
  assign mem_fire   = op_accept && is_mem;
  assign load_last  = busy_q && !m_write && (m_lane == LW'(LANES - 1));

  // register file
  logic [LANES-1:0] we_mask;
  logic [AW-1:0]    waddr;
  logic [VW-1:0]    wdata;
  logic [3*VW-1:0]  rd_all;
  logic [VW-1:0]    rd_a, rd_b, rd_dst, b_vec;
  logic [AW-1:0]    dst_rd_addr;

  assign dst_rd_addr = busy_q ? m_dst : op_dst;

  vx_regfile #(.NREG(NREG), .LANES(LANES), .EW(EW), .NRD(3)) u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_mask(we_mask),
    .waddr  (waddr),
    .wdata  (wdata),
    .raddr  ({dst_rd_addr, op_srcb, op_srca}),
    .rdata  (rd_all)
  );
  assign rd_a   = rd_all[0*VW +: VW];
  assign rd_b   = rd_all[1*VW +: VW];
  assign rd_dst = rd_all[2*VW +: VW];
  assign b_vec  = op_bscalar ? {LANES{op_scalar}} : rd_b;

  // lane arithmetic
  logic [VW-1:0]        alu_res;
  logic [LANES-1:0]     lane_en;
  logic [3*LANES-1:0]   flags_new;

  vx_alu #(.LANES(LANES), .EW(EW)) u_alu (
    .code     (op_code),
    .pred     (op_pred),
    .a_vec    (rd_a),
    .b_vec    (b_vec),
    .flags_in (flags_q),
    .res_vec  (alu_res),
    .lane_en  (lane_en),
    .flags_out(flags_new)
  );

  // addresses
  logic [VW-1:0] addr_vec;

  vx_agu #(.LANES(LANES), .EW(EW), .OFFW(OFFW)) u_agu (
    .base    (op_scalar),
    .offset  (op_offset),
    .idx_vec (rd_b),
    .gather  (is_gather),
    .addr_vec(addr_vec)
  );

  // write port selection
  always_comb begin
    we_mask = '0;
    waddr   = op_dst;
    wdata   = alu_res;
    if (busy_q) begin
      waddr = m_dst;
      wdata = {LANES{mem_rdata}};
      if (!m_write) we_mask = LANES'(1) << m_lane;
    end else if (arith_fire) begin
      we_mask = lane_en;
    end
  end

  logic [VW-1:0] merged;
  for (genvar l = 0; l < LANES; l++) begin : g_merge
    assign merged[l*EW +: EW] = we_mask[l] ? wdata[l*EW +: EW] : rd_dst[l*EW +: EW];
  end

  // sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      m_write     <= 1'b0;
      m_gather    <= 1'b0;
      m_lane      <= '0;
      m_dst       <= '0;
      m_addr      <= '0;
      m_wdata     <= '0;
      flags_q     <= '0;
      res_valid_q <= 1'b0;
      res_dst_q   <= '0;
      res_data_q  <= '0;
    end else begin
      res_valid_q <= arith_fire || load_last;
      if (arith_fire || load_last) begin
        res_dst_q  <= load_last ? m_dst : op_dst;
        res_data_q <= merged;
      end
      if (cmp_fire) flags_q <= flags_new;
      if (mem_fire) begin
        busy_q   <= 1'b1;
        m_lane   <= '0;
        m_write  <= is_store;
        m_gather <= is_gather;
        m_dst    <= op_dst;
        m_addr   <= addr_vec;
        m_wdata  <= rd_a;
      end else if (busy_q) begin
        if (m_lane == LW'(LANES - 1)) busy_q <= 1'b0;
        else                          m_lane <= m_lane + 1'b1;
      end
    end
  end

  assign busy          = busy_q;
  assign res_valid     = res_valid_q;
  assign res_dst       = res_dst_q;
  assign res_data      = res_data_q;
  assign flags         = flags_q;
  assign mem_req_valid = busy_q;
  assign mem_req_write = m_write;
  assign mem_req_lane  = m_lane;
  assign mem_req_addr  = m_addr[m_lane*EW +: EW];
  assign mem_req_wdata = m_wdata[m_lane*EW +: EW];
endmodule

// File: rtl/vx_exec_checker.sv
module vx_exec_checker #(
  parameter int LANES = 4,
  parameter int EW    = 32,
  parameter int AW    = 3,
  localparam int LW   = $clog2(LANES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               arith_fire,
  input logic               load_last,
  input logic               m_gather,
  input logic [AW-1:0]      op_dst,
  input logic               res_valid,
  input logic [AW-1:0]      res_dst,
  input logic [3*LANES-1:0] flags,
  input logic               mem_req_valid,
  input logic [LW-1:0]      mem_req_lane,
  input logic [EW-1:0]      mem_req_addr
);
  // R6: lanes advance by one per cycle
  p_lane_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_lane != LW'(LANES - 1)) |=>
      (mem_req_valid && mem_req_lane == $past(mem_req_lane) + 1'b1));

  // R6: the request burst ends after the last lane
  p_lane_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_lane == LW'(LANES - 1)) |=> !mem_req_valid);

  // R6: contiguous addresses step by four bytes
  p_addr_stride_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !m_gather && mem_req_lane != LW'(LANES - 1)) |=>
      (mem_req_addr == $past(mem_req_addr) + EW'(4)));

  // R2: accepted arithmetic reports its destination next cycle
  p_arith_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    arith_fire |=> (res_valid && res_dst == $past(op_dst)));

  // R9: load completion reports a result
  p_load_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_last |=> res_valid);

  // R10: no result appears mid-burst
  p_quiet_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !load_last) |=> !res_valid);

  // R4: at most one relation flag per lane
  for (genvar l = 0; l < LANES; l++) begin : g_fl
    p_flags_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(flags[l*3 +: 3]));
  end
endmodule

bind vpu_lane_exec vx_exec_checker #(.LANES(LANES), .EW(EW), .AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .arith_fire   (arith_fire),
  .load_last    (load_last),
  .m_gather     (m_gather),
  .op_dst       (op_dst),
  .res_valid    (res_valid),
  .res_dst      (res_dst),
  .flags        (flags),
  .mem_req_valid(mem_req_valid),
  .mem_req_lane (mem_req_lane),
  .mem_req_addr (mem_req_addr)
);

// File: tb/sim_vpu_lane_exec.sv
`timescale 1ns/1ps
module sim_vpu_lane_exec;
  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0, op_bscalar = 1'b0;
  logic [3:0] op_code = '0;
  logic [2:0] op_dst = '0, op_srca = '0, op_srcb = '0;
  logic [31:0] op_scalar = '0;
  logic [1:0] op_pred = '0;
  logic [11:0] op_offset = '0;
  logic busy, res_valid, mem_req_valid, mem_req_write;
  logic [2:0] res_dst;
  logic [127:0] res_data;
  logic [11:0] flags;
  logic [1:0] mem_req_lane;
  logic [31:0] mem_req_addr, mem_req_wdata, mem_rdata;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vpu_lane_exec u0 (.*);

  // bench memory: word array, combinational read, write at the edge
  logic [31:0] bmem [256];
  assign mem_rdata = bmem[mem_req_addr[9:2]];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) bmem[i] <= 32'hA000_0000 | i;
      bmem[14] <= 32'hFFFF_FFFB; bmem[15] <= 32'd7; bmem[16] <= 32'd7; bmem[17] <= 32'd20;
      bmem[64] <= 32'h20; bmem[65] <= 32'h08; bmem[66] <= 32'h30; bmem[67] <= 32'h04;
    end else if (mem_req_valid && mem_req_write) begin
      bmem[mem_req_addr[9:2]] <= mem_req_wdata;
    end
  end

  // bench model of the registers and flags
  logic [31:0] mreg [8][4];
  logic [11:0] mflags = '0;

  function automatic logic [127:0] pack(input int r);
    return {mreg[r][3], mreg[r][2], mreg[r][1], mreg[r][0]};
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drv(input logic [3:0] c, input logic [2:0] d, input logic [2:0] a,
                     input logic [2:0] b, input logic sc, input logic [31:0] s,
                     input logic [1:0] p, input logic [11:0] off);
    op_valid = 1'b1; op_code = c; op_dst = d; op_srca = a; op_srcb = b;
    op_bscalar = sc; op_scalar = s; op_pred = p; op_offset = off;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  // arithmetic and predicated forms: R2, R3, R5
  task automatic do_arith(input string tag, input logic [3:0] c, input logic [2:0] d,
                          input logic [2:0] a, input logic [2:0] b, input logic sc,
                          input logic [31:0] s, input logic [1:0] p);
    logic [31:0] nv [4];
    for (int l = 0; l < 4; l++) begin
      logic [31:0] x, y, r;
      logic en;
      x = mreg[a][l];
      y = sc ? s : mreg[b][l];
      r = (c == 4'd1 || c == 4'd4) ? 32'(x * y) : 32'(x + y);
      en = (c <= 4'd1) ? 1'b1 : (p == 2'd3) ? 1'b0 : mflags[l*3 + p];
      nv[l] = en ? r : mreg[d][l];
    end
    drv(c, d, a, b, sc, s, p, 12'd0);
    for (int l = 0; l < 4; l++) mreg[d][l] = nv[l];
    chk({tag, " res_valid"}, 128'(res_valid), 128'd1);
    chk({tag, " res_dst"}, 128'(res_dst), 128'(d));
    chk({tag, " res_data"}, res_data, pack(d));
  endtask

  task automatic read_reg(input string tag, input logic [2:0] r);
    do_arith(tag, 4'd0, r, r, 3'd0, 1'b1, 32'd0, 2'd0);
  endtask

  // compare: R4
  task automatic do_cmp(input string tag, input logic [2:0] a, input logic [2:0] b,
                        input logic sc, input logic [31:0] s);
    for (int l = 0; l < 4; l++) begin
      logic signed [31:0] x, y;
      x = mreg[a][l];
      y = sc ? s : mreg[b][l];
      mflags[l*3 +: 3] = {x > y, x == y, x < y};
    end
    drv(4'd2, 3'd6, a, b, sc, s, 2'd0, 12'd0);
    chk({tag, " R4 flags"}, 128'(flags), 128'(mflags));
    chk({tag, " R4 no res_valid"}, 128'(res_valid), 128'd0);
  endtask

  // memory instructions: R6, R7, R8, R9
  task automatic do_mem(input string tag, input logic [3:0] c, input logic [2:0] d,
                        input logic [2:0] a, input logic [2:0] b,
                        input logic [31:0] base, input logic [11:0] off);
    logic [31:0] ea [4];
    logic [31:0] wd [4];
    logic [31:0] ld [4];
    logic st, ga;
    st = (c == 4'd6 || c == 4'd8);
    ga = (c == 4'd7 || c == 4'd8);
    for (int l = 0; l < 4; l++) begin
      ea[l] = ga ? mreg[b][l] : base + {{20{off[11]}}, off} + 32'(4 * l);
      wd[l] = mreg[a][l];
    end
    drv(c, d, a, b, 1'b1, base, 2'd0, off);
    for (int l = 0; l < 4; l++) begin
      chk({tag, " R6 req_valid"}, 128'(mem_req_valid), 128'd1);
      chk({tag, " R6 lane"}, 128'(mem_req_lane), 128'(l));
      chk({tag, ga ? " R7 addr" : " R6 addr"}, 128'(mem_req_addr), 128'(ea[l]));
      chk({tag, " R8 write flag"}, 128'(mem_req_write), 128'(st));
      if (st) chk({tag, " R8 wdata"}, 128'(mem_req_wdata), 128'(wd[l]));
      ld[l] = bmem[ea[l][9:2]];
      @(negedge clk);
    end
    chk({tag, " busy cleared"}, 128'(busy), 128'd0);
    if (st) begin
      chk({tag, " R8 no res_valid"}, 128'(res_valid), 128'd0);
      for (int l = 0; l < 4; l++)
        chk({tag, " R8 memory"}, 128'(bmem[ea[l][9:2]]), 128'(wd[l]));
    end else begin
      for (int l = 0; l < 4; l++) mreg[d][l] = ld[l];
      chk({tag, " R9 res_valid"}, 128'(res_valid), 128'd1);
      chk({tag, " R9 res_dst"}, 128'(res_dst), 128'(d));
      chk({tag, " R9 res_data"}, res_data, pack(d));
    end
  endtask

  task automatic t_reset;
    chk("R1 res_valid", 128'(res_valid), 128'd0);
    chk("R1 busy", 128'(busy), 128'd0);
    chk("R1 mem_req_valid", 128'(mem_req_valid), 128'd0);
    chk("R1 flags", 128'(flags), 128'd0);
  endtask

  // R10: instruction offered in the middle of a load
  task automatic t_busy;
    logic [31:0] ea0;
    ea0 = 32'h40;
    drv(4'd5, 3'd0, 3'd0, 3'd0, 1'b1, ea0, 2'd0, 12'd0);
    chk("R10 busy high", 128'(busy), 128'd1);
    drv(4'd0, 3'd1, 3'd1, 3'd0, 1'b1, 32'd99, 2'd0, 12'd0);
    chk("R10 no res_valid mid-load", 128'(res_valid), 128'd0);
    drv(4'd2, 3'd0, 3'd1, 3'd0, 1'b1, 32'd0, 2'd0, 12'd0);
    chk("R10 flags unchanged", 128'(flags), 128'(mflags));
    @(negedge clk);
    @(negedge clk);
    for (int l = 0; l < 4; l++) mreg[0][l] = bmem[16 + l];
    chk("R10 load still completes", res_data, pack(0));
    read_reg("R10 vr1 untouched", 3'd1);
  endtask

  // R11: undefined opcodes
  task automatic t_undef;
    drv(4'd15, 3'd1, 3'd2, 3'd3, 1'b1, 32'd1, 2'd0, 12'd0);
    chk("R11 no res_valid", 128'(res_valid), 128'd0);
    chk("R11 not busy", 128'(busy), 128'd0);
    drv(4'd9, 3'd1, 3'd2, 3'd3, 1'b0, 32'd1, 2'd0, 12'd0);
    chk("R11 no memory request", 128'(mem_req_valid), 128'd0);
    chk("R11 flags unchanged", 128'(flags), 128'(mflags));
    read_reg("R11 vr1 untouched", 3'd1);
  endtask

  initial begin
    for (int r = 0; r < 8; r++) for (int l = 0; l < 4; l++) mreg[r][l] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    read_reg("R1 vr4 zero", 3'd4);
    do_arith("R2 scalar broadcast", 4'd0, 3'd1, 3'd0, 3'd0, 1'b1, 32'd5, 2'd0);
    do_mem("R9 contiguous load neg offset", 4'd5, 3'd2, 3'd0, 3'd0, 32'h40, 12'hFF8);
    do_arith("R2 vector add", 4'd0, 3'd3, 3'd2, 3'd1, 1'b0, 32'd0, 2'd0);
    do_arith("R2 wrap add", 4'd0, 3'd4, 3'd2, 3'd0, 1'b1, 32'hFFFF_FFFE, 2'd0);
    do_arith("R3 scalar mul", 4'd1, 3'd5, 3'd2, 3'd0, 1'b1, 32'h0001_0001, 2'd0);
    do_arith("R3 vector mul", 4'd1, 3'd5, 3'd4, 3'd4, 1'b0, 32'd0, 2'd0);
    do_cmp("R4 signed vs scalar", 3'd2, 3'd0, 1'b1, 32'd7);
    do_arith("R5 padd lt", 4'd3, 3'd6, 3'd2, 3'd0, 1'b1, 32'd100, 2'd0);
    do_arith("R5 pmul eq", 4'd4, 3'd6, 3'd2, 3'd0, 1'b1, 32'd3, 2'd1);
    do_arith("R5 padd none", 4'd3, 3'd6, 3'd2, 3'd0, 1'b1, 32'd1, 2'd3);
    do_arith("R5 padd gt vector", 4'd3, 3'd6, 3'd2, 3'd1, 1'b0, 32'd0, 2'd2);
    do_cmp("R4 vector compare", 3'd3, 3'd2, 1'b0, 32'd0);
    do_mem("R8 contiguous store", 4'd6, 3'd0, 3'd3, 3'd0, 32'h80, 12'd0);
    do_mem("R6 index load", 4'd5, 3'd7, 3'd0, 3'd0, 32'h100, 12'd0);
    do_mem("R7 gather", 4'd7, 3'd4, 3'd0, 3'd7, 32'd0, 12'd0);
    do_mem("R7 scatter", 4'd8, 3'd0, 3'd3, 3'd7, 32'd0, 12'd0);
    do_mem("R7 gather into own index", 4'd7, 3'd7, 3'd0, 3'd7, 32'd0, 12'd0);
    t_busy();
    t_undef();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule